// File: doc/BRIEF.md
# Four-Lane Serial Register-Access Master

This block is a synchronous serial master with four bidirectional data lanes and one serial clock, and a register bus drives it. Software or a DMA channel writes a word into the transmit register. The block then moves that word into its shift register and clocks it out one nibble per serial clock cycle. In the same cycles it takes in one nibble per clock from the lanes. A control bit turns the lanes around. When it selects input, all four output drivers are released, but a transfer still starts only when a word is written to the transmit register. In that case the written word is a dummy that only sets the clock running.

The transmit side has two stages, a holding buffer and the shift register. While one word is shifting, the next one can be queued, and it follows with no pause in the clock if it arrives before the current word's last falling edge. Completed input words land in a receive register with a full flag, which also serves as the interrupt line. A transfer-end flag marks the point where the shifter runs dry. A DMA request can be enabled so that it follows the transmit-empty flag. The slave-select output is a plain register bit under software control.

Top module: `qspi_master`

## Requirements
- R1: After reset, the slave select reads high, the serial clock is low, all lane output enables are 0, the interrupt and DMA request are 0, and the status register reads 0x01 (only transmit-empty set).
- R2: The control register sits at address 0. Bit 0 is the lane direction (1 = input, reset 1), bit 1 is the slave-select level (reset 1), bit 2 is the DMA enable (reset 0), and bits [11:8] hold the word length field (reset 15). While the direction bit is 1, all four output enables are 0; while it is 0, they are all 1.
- R3: The slave-select pin always equals control bit 1. Writing 0 asserts it (low) and writing 1 releases it.
- R4: A write to address 1 while transmit-empty is 1 stores the word and clears transmit-empty. Every transfer, input or output, starts only from such a write. A write to address 1 while transmit-empty is 0 is ignored and its word is never sent.
- R5: A word has (field[3:2]+1) nibbles, so the two low bits of the length field do not change the length (3 gives 4 bits, 15 gives 16 bits). The word is taken from the low bits of the written value and sent most significant nibble first, with lane 3 carrying the highest bit of each nibble. Lane data changes on the falling clock edge and is sampled on the rising edge. The clock idles low, and each clock half-period lasts HALF_DIV system clocks.
- R6: With the direction bit at 1, each completed word is placed right-aligned and zero-extended in the receive register (address 2), and receive-full is set. The interrupt output follows receive-full, and reading address 2 clears it. With the direction bit at 0, the receive register and receive-full are left unchanged.
- R7: If a word completes while receive-full is still 1, the overrun flag is set and the earlier word is kept. Writing 1 to status bit 3 clears overrun.
- R8: When a word finishes and no further word is queued, transfer-end is set and the serial clock stays low. Writing 1 to status bit 2 clears transfer-end.
- R9: The DMA request is high exactly when the DMA enable is 1 and transmit-empty is 1.
- R10: A word queued before the current word's last falling edge starts at once, and the interval between rising clock edges stays at 2*HALF_DIV system clocks across the word boundary.
- R11: The status register at address 3 reads bit 0 = transmit-empty, bit 1 = receive-full, bit 2 = transfer-end, bit 3 = overrun and bit 4 = shifter busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 2 | Register address |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (side effects on receive read) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from address |
| sclk | output | 1 | Serial clock |
| sdOut | output | 4 | Lane output data |
| sdOe | output | 4 | Lane output enables |
| sdIn | input | 4 | Lane input data |
| ssN | output | 1 | Slave select, active low |
| irq | output | 1 | Receive-full interrupt |
| dmaReq | output | 1 | DMA request for the transmit side |

## Verification
The hardest state to reach from the ports is a boundary between two words with no gap in the clock. It needs a second write to land inside the short window after the shifter has taken the first word and before that word's last falling edge, and that window lasts only a few system clocks. The stimulus polls status until transmit-empty returns to 1 with busy set. It then writes the next word at once, follows it with a third write that must be dropped, and times every rising clock edge across the boundary. Overrun is reached by the same kind of chained dummy writes in input direction, with no read of the receive register in between.

// File: rtl/qspi_master_pkg.sv
package qspi_master_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_TX   = 2'd1;
  localparam logic [1:0] ADDR_RX   = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic txLoad;     // capture bus word into holding buffer
    logic shiftLoad;  // move holding buffer into shifter
    logic sampleNib;  // capture lane inputs (rising sclk)
    logic shiftStep;  // advance shifter one nibble (falling sclk)
    logic rxCapture;  // store completed word into receive register
  } dpStrobes_t;
endpackage

// File: rtl/qspi_master_ctl.sv
module qspi_master_ctl
  import qspi_master_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int BUS_W    = 32,
  parameter int HALF_DIV = 2,
  localparam int LEN_W   = $clog2(DATA_W),
  localparam int NIB_W   = LEN_W - 1,
  localparam int DIV_W   = $clog2(HALF_DIV + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [BUS_W-1:0]  regWdata,
  output logic [BUS_W-1:0]  regRdata,
  input  logic [DATA_W-1:0] rxWord,
  output logic [NIB_W-1:0]  nibbles,
  output dpStrobes_t        stb,
  output logic              sclk,
  output logic              ssN,
  output logic              dirIn,
  output logic              dmaEn,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              xferEnd,
  output logic              overrun,
  output logic              busy
);
  logic [LEN_W-1:0] lenField;
  logic [DIV_W-1:0] divCnt;
  logic [NIB_W-1:0] nibLeft;
  logic             tick, lastFall, txWrOk, rxRdHit, statWr, startIdle, chainNext;
  logic [BUS_W-1:0] ctrlView, statView;

  assign nibbles = {1'b0, lenField[LEN_W-1:2]} + NIB_W'(1);

  always_comb begin
    tick      = busy && (divCnt == DIV_W'(HALF_DIV - 1));
    lastFall  = tick && sclk && (nibLeft == NIB_W'(1));
    txWrOk    = regWr && (regAddr == ADDR_TX) && txEmpty;
    rxRdHit   = regRd && (regAddr == ADDR_RX);
    statWr    = regWr && (regAddr == ADDR_STAT);
    startIdle = !busy && !txEmpty;
    chainNext = lastFall && !txEmpty;
    stb.txLoad    = txWrOk;
    stb.shiftLoad = startIdle || chainNext;
    stb.sampleNib = tick && !sclk;
    stb.shiftStep = tick && sclk;
    stb.rxCapture = lastFall && dirIn && (!rxFull || rxRdHit);
  end

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirIn    <= 1'b1;
      ssN      <= 1'b1;
      dmaEn    <= 1'b0;
      lenField <= LEN_W'(DATA_W - 1);
    end else if (regWr && regAddr == ADDR_CTRL) begin
      dirIn    <= regWdata[0];
      ssN      <= regWdata[1];
      dmaEn    <= regWdata[2];
      lenField <= regWdata[8 +: LEN_W];
    end
  end

  // serial sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      divCnt  <= '0;
      nibLeft <= '0;
    end else begin
      if (stb.shiftLoad)   busy <= 1'b1;
      else if (lastFall)   busy <= 1'b0;
      if (stb.shiftLoad || tick) divCnt <= '0;
      else if (busy)             divCnt <= divCnt + DIV_W'(1);
      if (tick) sclk <= ~sclk;
      if (stb.shiftLoad)     nibLeft <= nibbles;
      else if (stb.shiftStep) nibLeft <= nibLeft - NIB_W'(1);
    end
  end

  // flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEmpty <= 1'b1;
      rxFull  <= 1'b0;
      xferEnd <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (txWrOk)             txEmpty <= 1'b0;
      else if (stb.shiftLoad) txEmpty <= 1'b1;
      if (stb.rxCapture)      rxFull <= 1'b1;
      else if (rxRdHit)       rxFull <= 1'b0;
      if (lastFall && !chainNext && !txWrOk) xferEnd <= 1'b1;
      else if (statWr && regWdata[2])        xferEnd <= 1'b0;
      if (lastFall && dirIn && rxFull && !rxRdHit) overrun <= 1'b1;
      else if (statWr && regWdata[3])              overrun <= 1'b0;
    end
  end

  // read mux
  always_comb begin
    ctrlView = '0;
    ctrlView[0] = dirIn;
    ctrlView[1] = ssN;
    ctrlView[2] = dmaEn;
    ctrlView[8 +: LEN_W] = lenField;
    statView = {{(BUS_W-5){1'b0}}, busy, overrun, xferEnd, rxFull, txEmpty};
    case (regAddr)
      ADDR_CTRL: regRdata = ctrlView;
      ADDR_RX:   regRdata = BUS_W'(rxWord);
      ADDR_STAT: regRdata = statView;
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/qspi_master_dp.sv
module qspi_master_dp
  import qspi_master_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int LEN_W = $clog2(DATA_W),
  localparam int NIB_W = LEN_W - 1,
  localparam int SH_W  = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NIB_W-1:0]  nibbles,
  input  logic [3:0]        sdIn,
  output logic [3:0]        sdOut,
  output logic [DATA_W-1:0] rxWord
);
  logic [DATA_W-1:0] txBuf, shiftReg, shiftNext;
  logic [3:0]        inNib;
  logic [SH_W-1:0]   bitsCnt, shamt;

  always_comb begin
    bitsCnt   = {nibbles, 2'b00};
    shamt     = SH_W'(DATA_W) - bitsCnt;
    shiftNext = {shiftReg[DATA_W-5:0], inNib};
  end

  assign sdOut = shiftReg[DATA_W-1 -: 4];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf    <= '0;
      shiftReg <= '0;
      inNib    <= '0;
      rxWord   <= '0;
    end else begin
      if (stb.txLoad)    txBuf <= wdata;
      if (stb.sampleNib) inNib <= sdIn;
      // word left-aligned so the first nibble sits at the top
      if (stb.shiftLoad)      shiftReg <= txBuf << shamt;
      else if (stb.shiftStep) shiftReg <= shiftNext;
      if (stb.rxCapture) rxWord <= shiftNext;
    end
  end
endmodule

// File: rtl/qspi_master.sv
module qspi_master
  import qspi_master_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int BUS_W    = 32,
  parameter int HALF_DIV = 2,
  localparam int LEN_W   = $clog2(DATA_W),
  localparam int NIB_W   = LEN_W - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [BUS_W-1:0] regWdata,
  output logic [BUS_W-1:0] regRdata,
  output logic             sclk,
  output logic [3:0]       sdOut,
  output logic [3:0]       sdOe,
  input  logic [3:0]       sdIn,
  output logic             ssN,
  output logic             irq,
  output logic             dmaReq
);
  dpStrobes_t        stb;
  logic [DATA_W-1:0] rxWord;
  logic [NIB_W-1:0]  nibbles;
  logic dirIn, dmaEn, txEmpty, rxFull, xferEnd, overrun, busy;

  qspi_master_ctl #(.DATA_W(DATA_W), .BUS_W(BUS_W), .HALF_DIV(HALF_DIV)) u_ctl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .rxWord(rxWord), .nibbles(nibbles),
    .stb(stb), .sclk(sclk), .ssN(ssN), .dirIn(dirIn), .dmaEn(dmaEn),
    .txEmpty(txEmpty), .rxFull(rxFull), .xferEnd(xferEnd), .overrun(overrun),
    .busy(busy)
  );

  qspi_master_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(regWdata[DATA_W-1:0]),
    .nibbles(nibbles), .sdIn(sdIn), .sdOut(sdOut), .rxWord(rxWord)
  );

  assign sdOe   = {4{~dirIn}};
  assign irq    = rxFull;
  assign dmaReq = dmaEn & txEmpty;
endmodule

// File: rtl/qspi_master_chk.sv
module qspi_master_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sclk,
  input logic [3:0] sdOut,
  input logic       txEmpty,
  input logic       rxFull,
  input logic       xferEnd,
  input logic       overrun,
  input logic       busy,
  input logic       dmaReq
);
  // R5
  sdout_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(sdOut));

  // R5
  sclk_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> busy);

  // R8
  end_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferEnd) |-> (!sclk && !busy));

  // R7
  overrun_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> rxFull);

  // R9
  dma_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEmpty |-> !dmaReq);
endmodule

bind qspi_master qspi_master_chk u_chk (
  .clk(clk), .rstN(rstN), .sclk(sclk), .sdOut(sdOut), .txEmpty(txEmpty),
  .rxFull(rxFull), .xferEnd(xferEnd), .overrun(overrun), .busy(busy),
  .dmaReq(dmaReq)
);

// File: tb/qspi_master_bench.sv
module qspi_master_bench;
  localparam int HALF = 2;
  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [31:0] regWdata = '0, regRdata;
  logic sclk, ssN, irq, dmaReq;
  logic [3:0] sdOut, sdOe;
  logic [3:0] sdIn = '0;

  qspi_master #(.DATA_W(16), .BUS_W(32), .HALF_DIV(HALF)) u_qspi_master (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .sclk(sclk), .sdOut(sdOut),
    .sdOe(sdOe), .sdIn(sdIn), .ssN(ssN), .irq(irq), .dmaReq(dmaReq)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [15:0] txExpQ[$], slvQ[$], rxExpQ[$];
  logic [15:0] curSlv = '0, acc = '0;
  int slvLen = 4, idx = 0;
  bit monTx = 0, gapWatch = 0;
  longint lastRise = 0, maxGap = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] lenMask(input int n);
    return (n >= 4) ? 16'hFFFF : 16'((32'd1 << (4*n)) - 1);
  endfunction

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // slave model and transmit monitor: sample on rising sclk, drive on falling
  always @(posedge sclk) begin
    if (gapWatch) begin
      if (lastRise != 0 && ($time - lastRise) > maxGap) maxGap = $time - lastRise;
      lastRise = $time;
    end
    acc = {acc[11:0], sdOut};
    idx++;
    if (idx == slvLen) begin
      if (monTx) begin
        if (txExpQ.size() == 0) chk(0, "R4 unexpected word sent", acc & lenMask(slvLen), 0);
        else begin
          logic [15:0] e;
          e = txExpQ.pop_front() & lenMask(slvLen);
          chk((acc & lenMask(slvLen)) == e, "R5 serial word", acc & lenMask(slvLen), e);
        end
      end
      idx = 0;
      curSlv = (slvQ.size() != 0) ? slvQ.pop_front() : 16'h0;
    end
  end
  always @(negedge sclk) sdIn = curSlv[(slvLen-1-idx)*4 +: 4];

  task automatic primeSlave();
    curSlv = slvQ.pop_front();
    idx = 0;
    sdIn = curSlv[(slvLen-1)*4 +: 4];
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk); regRd = 1'b0;
  endtask

  // driver: queue the expected word, then write it
  task automatic sendWord(input logic [15:0] w);
    if (monTx) txExpQ.push_back(w);
    regWrite(2'd1, {16'h0, w});
  endtask

  task automatic waitStat(input int b, input string tag);
    logic [31:0] s;
    int n = 0;
    do begin regRead(2'd3, s); n++; end while (!s[b] && n < 500);
    chk(s[b], tag, s, 1);
  endtask

  logic [31:0] rd;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ssN && !sclk && sdOe == 4'h0 && !irq && !dmaReq, "R1 reset pins",
        {ssN, sclk, sdOe, irq, dmaReq}, 8'h80);
    regRead(2'd3, rd);
    chk(rd == 32'h1, "R1 R11 reset status", rd, 1);
    regRead(2'd0, rd);
    chk(rd == 32'h0F03, "R2 reset control", rd, 32'h0F03);

    // output direction, select asserted, 16-bit words
    regWrite(2'd0, 32'h0F00);
    chk(!ssN, "R3 select asserted", ssN, 0);
    chk(sdOe == 4'hF, "R2 output enables on", sdOe, 4'hF);
    monTx = 1; slvLen = 4;
    slvQ.push_back(16'h7777); primeSlave();
    sendWord(16'hA5C3);
    waitStat(2, "R8 transfer end");
    chk(!sclk, "R8 clock idle low", sclk, 0);
    chk(txExpQ.size() == 0, "R5 word delivered", txExpQ.size(), 0);
    regRead(2'd3, rd);
    chk(rd[1] == 1'b0, "R6 no capture in output direction", rd[1], 0);
    regWrite(2'd3, 32'h4);
    regRead(2'd3, rd);
    chk(rd[2] == 1'b0, "R8 transfer end cleared", rd[2], 0);

    // back-to-back with a dropped third write
    gapWatch = 1; lastRise = 0; maxGap = 0;
    sendWord(16'h1234);
    do regRead(2'd3, rd); while (!(rd[0] && rd[4]));
    sendWord(16'h5678);
    regWrite(2'd1, 32'h9ABC);          // full: must be ignored
    regRead(2'd3, rd);
    chk(rd[0] == 1'b0, "R4 buffer still holds queued word", rd[0], 0);
    waitStat(2, "R8 burst end");
    gapWatch = 0;
    chk(maxGap == 2*HALF*10, "R10 gapless rise interval", maxGap, 2*HALF*10);
    chk(txExpQ.size() == 0, "R4 queued word delivered", txExpQ.size(), 0);
    regWrite(2'd3, 32'h4);

    // 4-bit words: field 3, only low nibble sent
    regWrite(2'd0, 32'h0300);
    slvLen = 1;
    txExpQ.push_back(16'h0009);
    regWrite(2'd1, 32'hFFF9);
    waitStat(2, "R8 short word end");
    chk(txExpQ.size() == 0, "R5 nibble word delivered", txExpQ.size(), 0);
    regWrite(2'd3, 32'h4);

    // input direction
    monTx = 0; slvLen = 4;
    regWrite(2'd0, 32'h0F01);
    chk(sdOe == 4'h0, "R2 output enables off", sdOe, 0);
    slvQ.push_back(16'hBEEF); primeSlave();
    rxExpQ.push_back(16'hBEEF);
    regWrite(2'd1, 32'h0);
    @(posedge sclk); #1;
    chk(sdOe == 4'h0, "R2 lanes released during receive", sdOe, 0);
    waitStat(1, "R6 receive full");
    chk(irq, "R6 interrupt", irq, 1);
    regRead(2'd2, rd);
    begin
      logic [15:0] e;
      e = rxExpQ.pop_front();
      chk(rd == {16'h0, e}, "R6 received word", rd, e);
    end
    chk(!irq, "R6 interrupt cleared by read", irq, 0);
    regWrite(2'd3, 32'h4);

    // overrun
    slvQ.push_back(16'h1111); slvQ.push_back(16'h2222); primeSlave();
    regWrite(2'd1, 32'h0);
    waitStat(2, "R8 first rx end");
    regWrite(2'd3, 32'h4);
    regWrite(2'd1, 32'h0);
    waitStat(2, "R8 second rx end");
    regRead(2'd3, rd);
    chk(rd[3], "R7 overrun set", rd[3], 1);
    regRead(2'd2, rd);
    chk(rd == 32'h1111, "R7 first word kept", rd, 32'h1111);
    regWrite(2'd3, 32'hC);
    regRead(2'd3, rd);
    chk(rd[3] == 1'b0, "R7 overrun cleared", rd[3], 0);

    // DMA request
    regWrite(2'd0, 32'h0F05);
    chk(dmaReq, "R9 request while empty", dmaReq, 1);
    slvQ.push_back(16'h0F0F); primeSlave();
    regWrite(2'd1, 32'h0);
    chk(!dmaReq, "R9 request drops when buffer full", dmaReq, 0);
    waitStat(2, "R8 dma word end");
    chk(dmaReq, "R9 request back when empty", dmaReq, 1);
    regWrite(2'd0, 32'h0F03);
    chk(!dmaReq && ssN, "R3 R9 select released and request off", {ssN, dmaReq}, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule